// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes an asynchronous serial line, recovers the characters on it and queues them for a host. A programmable divisor turns the system clock into a tick at sixteen times the bit rate. The incoming line is resynchronised first. A frame engine then finds the start bit, samples every following bit near its centre and drops the start, parity and stop bits. It checks parity and the stop level and hands the byte and its two error flags to a 32-entry queue.

The host sees the oldest queued byte at the read port, together with the framing and parity flags captured for that byte. A one-cycle pop moves on to the next entry. A byte-ready output shows that the queue holds data. When a frame completes while the queue is full, the byte is dropped and a sticky overrun flag is raised. The flag stays set until the host clears it.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, byte_ready and overrun are 0.
- R2: A frame is a low start bit, 8 data bits sent least significant bit first, an optional parity bit and one high stop bit, with the idle line high. Exactly one queue entry is made per completed frame. It holds only the 8 data bits in their original order, with no start, parity or stop bits.
- R3: One bit lasts 16*(baud_div+1) clock cycles. Every bit is sampled near its centre, so frames are received correctly at baud_div=0 and at baud_div=2.
- R4: A low pulse on an idle line that ends before the middle of a bit time (8 ticks) is treated as a glitch and makes no queue entry.
- R5: With par_en=1, a parity bit follows the data bits. par_odd=0 selects even parity and par_odd=1 selects odd parity, counting the data ones plus the parity bit. A mismatch sets rd_par_err for that entry. With par_en=0 there is no parity bit and rd_par_err is 0.
- R6: A stop bit sampled low sets rd_frame_err for that entry, and the byte is still queued.
- R7: The queue holds 32 entries in arrival order. rd_data and its flags show the oldest entry, and a pop advances to the next one. A pop while the queue is empty has no effect.
- R8: byte_ready is 1 exactly when the queue holds at least one entry.
- R9: A frame that completes while the queue is full and not being popped is dropped and sets overrun. overrun stays 1 until ovr_clear is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R10: The error flags at the read port belong to the entry being shown, not to the most recent frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| baud_div | input | 16 | Tick period is baud_div+1 clocks |
| pop | input | 1 | Remove the entry shown at the read port |
| ovr_clear | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 8 | Oldest queued byte |
| rd_frame_err | output | 1 | Stop-bit error of the shown byte |
| rd_par_err | output | 1 | Parity error of the shown byte |
| overrun | output | 1 | Sticky overrun flag |
| byte_ready | output | 1 | Queue holds at least one entry |

## Verification
The bench uses the default parameters: a 32-entry queue, a two-flop synchroniser and a 16-bit divisor. Most frames run at baud_div=0, where one bit is only 16 clocks. This makes it practical to fill all 32 entries and then send one more frame, which reaches the full-queue drop and the overrun path. One frame is also sent at baud_div=2 to show that the tick generator stretches every bit evenly and that sampling still lands near the bit centre.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int TICK_W = $clog2(OSR);
    localparam int BIDX_W = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              par_err;
        logic              frm_err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             tick_d, tick_q;

    always_comb begin
        if (cnt_q >= div) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end else begin
            cnt_d  = cnt_q + 1'b1;
            tick_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_entry_t entry
);
    localparam logic [TICK_W-1:0] MID  = TICK_W'(OSR/2 - 1);
    localparam logic [TICK_W-1:0] LAST = TICK_W'(OSR - 1);
    localparam logic [BIDX_W-1:0] TOPB = BIDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [TICK_W-1:0] tcnt;
        logic [BIDX_W-1:0] bidx;
        logic [DATA_W-1:0] sh;
        logic              perr;
        logic              ferr;
        logic              armed;
        logic              done;
    } frm_t;

    frm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (tick) begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (rx) begin
                        s_d.armed = 1'b1;
                    end else if (s_q.armed) begin
                        s_d.st    = ST_START;
                        s_d.tcnt  = '0;
                        s_d.armed = 1'b0;
                    end
                end
                ST_START: begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == MID) begin
                        s_d.tcnt = '0;
                        s_d.bidx = '0;
                        s_d.perr = 1'b0;
                        if (rx) begin
                            s_d.st    = ST_IDLE;
                            s_d.armed = 1'b1;
                        end else begin
                            s_d.st = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == LAST) begin
                        s_d.sh   = {rx, s_q.sh[DATA_W-1:1]};
                        s_d.bidx = s_q.bidx + 1'b1;
                        if (s_q.bidx == TOPB)
                            s_d.st = par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == LAST) begin
                        s_d.perr = ((^s_q.sh) ^ rx) != par_odd;
                        s_d.st   = ST_STOP;
                    end
                end
                ST_STOP: begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                    if (s_q.tcnt == LAST) begin
                        s_d.ferr  = ~rx;
                        s_d.done  = 1'b1;
                        s_d.st    = ST_IDLE;
                        s_d.armed = rx;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.armed <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done          = s_q.done;
    assign entry.data    = s_q.sh;
    assign entry.frm_err = s_q.ferr;
    assign entry.par_err = s_q.perr;
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      pop,
    input  logic      ovr_clear,
    output rx_entry_t rdata,
    output logic      not_empty,
    output logic      ovr,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } fifo_t;

    fifo_t f_d, f_q;
    rx_entry_t mem [DEPTH];
    logic do_push, do_pop, full, empty;

    always_comb begin
        empty   = (f_q.cnt == '0);
        full    = (f_q.cnt == CW'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        f_d     = f_q;
        if (do_push) f_d.wp = (f_q.wp == PMAX) ? '0 : f_q.wp + 1'b1;
        if (do_pop)  f_d.rp = (f_q.rp == PMAX) ? '0 : f_q.rp + 1'b1;
        if (do_push && !do_pop)      f_d.cnt = f_q.cnt + 1'b1;
        else if (do_pop && !do_push) f_d.cnt = f_q.cnt - 1'b1;
        if (ovr_clear) f_d.ovr = 1'b0;
        if (push && !do_push) f_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wp] <= wdata;
    end

    assign rdata     = mem[f_q.rp];
    assign not_empty = !empty;
    assign ovr       = f_q.ovr;
    assign count     = f_q.cnt;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 32,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              pop,
    input  logic              ovr_clear,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              rd_par_err,
    output logic              overrun,
    output logic              byte_ready
);
    logic             rx_s, tick, frame_vld;
    rx_entry_t        frame_entry, head;
    logic [CNT_W-1:0] fifo_cnt;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(rx_in), .q_out(rx_s)
    );

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .par_en(par_en), .par_odd(par_odd),
        .done(frame_vld), .entry(frame_entry)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(frame_vld), .wdata(frame_entry),
        .pop(pop), .ovr_clear(ovr_clear), .rdata(head),
        .not_empty(byte_ready), .ovr(overrun), .count(fifo_cnt)
    );

    assign rd_data      = head.data;
    assign rd_frame_err = head.frm_err;
    assign rd_par_err   = head.par_err;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pop,
    input logic          ovr_clear,
    input logic          byte_ready,
    input logic          overrun,
    input logic [7:0]    rd_data,
    input logic          frame_vld,
    input logic [CW-1:0] fifo_cnt
);
    // R9: overrun is sticky until cleared
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clear) |=> overrun);

    // R9: overrun only rises after a frame met a full, unpopped queue
    p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(frame_vld && fifo_cnt == CW'(DEPTH) && !pop));

    // R8: an empty queue stays empty unless a frame completes
    p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_ready && !frame_vld) |=> !byte_ready);

    // R7: shown entry is stable while not popped
    p_head_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && !pop) |=> (byte_ready && $stable(rd_data)));

    // R7: occupancy never exceeds the depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));
endmodule

bind serial_rx_core serial_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pop(pop), .ovr_clear(ovr_clear),
    .byte_ready(byte_ready), .overrun(overrun), .rd_data(rd_data),
    .frame_vld(frame_vld), .fifo_cnt(fifo_cnt)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic [15:0] baud_div = '0;
    logic        pop = 1'b0;
    logic        ovr_clear = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_frame_err, rd_par_err, overrun, byte_ready;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    serial_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .par_en(par_en),
        .par_odd(par_odd), .baud_div(baud_div), .pop(pop),
        .ovr_clear(ovr_clear), .rd_data(rd_data),
        .rd_frame_err(rd_frame_err), .rd_par_err(rd_par_err),
        .overrun(overrun), .byte_ready(byte_ready)
    );

    // vector fields: [7:0] data, [8] par_en, [9] par_odd, [10] flip parity, [11] stop low
    localparam logic [11:0] VEC [8] = '{
        12'h0_A5, 12'h0_01, 12'h1_3C, 12'h3_3C,
        12'h5_77, 12'h7_80, 12'h8_5A, 12'hD_FF
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, input int bclk);
        rx_in = b;
        repeat (bclk) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit pen, input bit podd,
                              input bit flip, input bit stop_low, input int div);
        int bclk = 16 * (div + 1);
        par_en  = pen;
        par_odd = podd;
        put_bit(1'b0, bclk);
        for (int i = 0; i < 8; i++) put_bit(d[i], bclk);
        if (pen) put_bit((^d) ^ podd ^ flip, bclk);
        put_bit(!stop_low, bclk);
        put_bit(1'b1, 2 * bclk);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(byte_ready == 1'b0, "R1 byte_ready", byte_ready, 0);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R5 R6 R10: table of frames
        for (int v = 0; v < 8; v++) begin
            logic [11:0] e = VEC[v];
            send_frame(e[7:0], e[8], e[9], e[10], e[11], 0);
            check(byte_ready, "R8 ready after frame", byte_ready, 1);
            check(rd_data == e[7:0], "R2 data", rd_data, e[7:0]);
            check(rd_par_err == (e[8] & e[10]), "R5 parity flag", rd_par_err, e[8] & e[10]);
            check(rd_frame_err == e[11], "R6 frame flag", rd_frame_err, e[11]);
            do_pop();
            check(!byte_ready, "R2 one entry per frame", byte_ready, 0);
        end

        // R10: flags stay with their own byte
        send_frame(8'h11, 1, 0, 1, 0, 0);
        send_frame(8'h22, 0, 0, 0, 1, 0);
        check(rd_data == 8'h11 && rd_par_err && !rd_frame_err, "R10 first entry flags",
              {rd_par_err, rd_frame_err, rd_data}, 10'h211);
        do_pop();
        check(rd_data == 8'h22 && !rd_par_err && rd_frame_err, "R10 second entry flags",
              {rd_par_err, rd_frame_err, rd_data}, 10'h122);
        do_pop();

        // R3: slower divisor
        baud_div = 16'd2;
        repeat (10) @(negedge clk);
        send_frame(8'hC3, 1, 1, 0, 0, 2);
        check(rd_data == 8'hC3 && !rd_par_err && !rd_frame_err, "R3 div=2 frame",
              {rd_par_err, rd_frame_err, rd_data}, 10'h0C3);
        do_pop();
        baud_div = 16'd0;
        repeat (10) @(negedge clk);

        // R4: short glitch ignored, then a real frame still received
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (64) @(negedge clk);
        check(!byte_ready, "R4 glitch ignored", byte_ready, 0);
        send_frame(8'h96, 0, 0, 0, 0, 0);
        check(rd_data == 8'h96, "R4 frame after glitch", rd_data, 8'h96);
        do_pop();

        // R7 R9: fill queue, overflow, order, sticky flag
        for (int i = 0; i < 32; i++) send_frame(8'h40 + 8'(i), 0, 0, 0, 0, 0);
        check(!overrun, "R9 no overrun at exactly full", overrun, 0);
        send_frame(8'hEE, 0, 0, 0, 0, 0);
        check(overrun, "R9 overrun set", overrun, 1);
        for (int i = 0; i < 32; i++) begin
            check(rd_data == 8'h40 + 8'(i), "R7 order", rd_data, 8'h40 + i);
            do_pop();
        end
        check(!byte_ready, "R9 dropped byte not stored", byte_ready, 0);
        check(overrun, "R9 overrun sticky", overrun, 1);
        ovr_clear = 1'b1;
        @(negedge clk);
        ovr_clear = 1'b0;
        @(negedge clk);
        check(!overrun, "R9 overrun cleared", overrun, 0);

        // R7: pop on empty has no effect
        do_pop();
        send_frame(8'h5A, 0, 0, 0, 0, 0);
        check(rd_data == 8'h5A && byte_ready, "R7 pop on empty ignored", rd_data, 8'h5A);
        do_pop();
        check(!byte_ready, "R8 empty after single pop", byte_ready, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule